// File: doc/BRIEF.md
# Multi-Core Dithered Activity Pattern Generator

This block drives one activity bit per processor core. Each bit follows a periodic square pattern: a run of high-activity cycles, then a run of low-activity cycles, over and over. If every core ran the same pattern freely, the relative phase between cores would never change. Any misalignment present at start would then stay for the whole run. This block instead makes every core except the first slip its phase on a schedule. Over one sweep, every combination of relative offsets between cores is held for a fixed sustain window.

Software loads the run-time settings and pulses a start strobe. The settings are the high length, low length, sustain window, active core count and mismatch tolerance, plus a mode bit. Core 0 is never slipped and serves as the reference. Each other core c inserts idle padding cycles. The padding interval for core c is the sustain window times the phase-step count raised to the power c-1. In exact mode each padding event is one cycle and the step count is the full period. In approximate mode each padding event is δ+1 cycles and the step count is the period divided by δ+1, which shrinks the sweep. A padding flag per core marks the inserted cycles. A one-cycle done pulse closes the sweep.

Top module: `dither_pattern_gen`

## Requirements
- R1: After reset, and whenever no sweep is running, every activity bit and padding bit is 0 and `busy` is 0.
- R2: Core 0 never pads. In the first cycle after the start strobe is taken, its pattern position is 0. Its bit is 1 while the position is below `cfg_high` and 0 for the remaining `cfg_low` positions of each period P = `cfg_high`+`cfg_low`.
- R3: In exact mode (`approx_en`=0), core c ≥ 1 pads for one cycle at every sweep cycle t with t ≥ I and t mod I = 0. Here I = M·P^(c-1), M = `cfg_sustain`, and t = 0 is the first running cycle.
- R4: During a padding cycle, that core's activity bit is 0 and its `pad` bit is 1. Its pattern position does not advance, so the pattern resumes where it stopped.
- R5: In approximate mode (`approx_en`=1), with k = P/(δ+1) and δ = `cfg_delta`, core c ≥ 1 pads for δ+1 consecutive cycles starting at each multiple t ≥ I of I = M·k^(c-1).
- R6: A sweep keeps `busy` at 1 for exactly M·P^(C-1) cycles in exact mode, or M·k^(C-1) cycles in approximate mode, where C = `cfg_cores`. `done` is 1 for the single cycle after the last one, and `done` never lasts two cycles.
- R7: A start is refused, with `cfg_err` set to 1 and no sweep run, in any of these cases: P = 0; M = 0; C = 0 or C > NCORES; the padding length exceeds M; or approximate mode is selected and P is not a multiple of δ+1. The next accepted start clears `cfg_err`.
- R8: Cores with index ≥ C keep activity and padding at 0 for the whole sweep.
- R9: A start strobe during a running sweep is ignored. The settings latched at the accepted start stay in force until the sweep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken only when idle |
| approx_en | input | 1 | 1 selects approximate (coarse-step) mode |
| cfg_high | input | FW | High-activity cycles per period |
| cfg_low | input | FW | Low-activity cycles per period |
| cfg_sustain | input | MW | Sustain window M |
| cfg_cores | input | CNW | Number of active cores C |
| cfg_delta | input | FW | Mismatch tolerance δ for approximate mode |
| act | output | NCORES | Per-core activity bit |
| pad | output | NCORES | Per-core padding indicator |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| cfg_err | output | 1 | Last start refused for an invalid setting |

## Verification
Two lanes can pad in the same cycle whenever a multiple of the higher lane's interval is reached: for example, cores 1 and 2 both pad at t = M·P. Also, the last sweep cycle can coincide with a padding cycle. Directed sweeps with three and four cores reach both coincidences. Randomised settings add more of them. Every running cycle, the full activity and padding vectors are compared against a closed-form model. That model counts the padding cycles inserted before each cycle, so a pad that is lost, doubled or shifted on one lane shows up at the exact cycle it occurs.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

    localparam int unsigned FW = 8;
    localparam int unsigned PW = FW + 1;
    localparam int unsigned MW = 16;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic [FW-1:0] high;
        logic [PW-1:0] period;
        logic [PW-1:0] plen;
    } lane_cfg_t;

    function automatic logic in_high(input logic [PW-1:0] pos, input logic [FW-1:0] high);
        return pos < {1'b0, high};
    endfunction

endpackage

// File: rtl/dpg_setup.sv
module dpg_setup
    import dpg_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int CW     = 32,
    parameter int CNW    = 3
) (
    input  logic            approx_en,
    input  logic [FW-1:0]   high,
    input  logic [FW-1:0]   low,
    input  logic [MW-1:0]   sustain,
    input  logic [FW-1:0]   delta,
    input  logic [CNW-1:0]  cores,
    output lane_cfg_t       lcfg,
    output logic [CW-1:0]   pw [NCORES],
    output logic            cfg_ok
);
    logic [PW-1:0] period;
    logic [PW-1:0] dp1;
    logic [PW-1:0] rem;
    logic [PW-1:0] step;
    logic [PW-1:0] plen;

    always_comb begin
        period = {1'b0, high} + {1'b0, low};
        dp1    = {1'b0, delta} + PW'(1);
        rem    = period % dp1;
        step   = approx_en ? (period / dp1) : period;
        plen   = approx_en ? dp1 : PW'(1);
    end

    // interval chain: pw[j] = M * step^j
    assign pw[0] = CW'(sustain);
    for (genvar j = 1; j < NCORES; j++) begin : g_pow
        assign pw[j] = CW'(pw[j-1] * CW'(step));
    end

    always_comb begin
        lcfg.high   = high;
        lcfg.period = period;
        lcfg.plen   = plen;
        cfg_ok = (period != '0) && (sustain != '0) && (cores != '0)
              && (32'(cores) <= 32'(NCORES))
              && (CW'(plen) <= CW'(sustain))
              && (!approx_en || rem == '0);
    end

endmodule

// File: rtl/dpg_lane.sv
module dpg_lane
    import dpg_pkg::*;
#(
    parameter int CW     = 32,
    parameter bit IS_REF = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic          en,
    input  logic [CW-1:0] ivl,
    input  lane_cfg_t     lcfg,
    output logic          act_o,
    output logic          pad_o
);
    logic [PW-1:0] ph_q;
    logic [CW-1:0] ic_q;
    logic [PW-1:0] pr_q;
    logic          slip;

    assign slip = !IS_REF && (ic_q == ivl - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ph_q <= '0;
            ic_q <= '0;
            pr_q <= '0;
        end else if (run && en) begin
            if (pr_q == '0)
                ph_q <= (ph_q == lcfg.period - PW'(1)) ? '0 : ph_q + PW'(1);
            if (slip)
                pr_q <= lcfg.plen;
            else if (pr_q != '0)
                pr_q <= pr_q - PW'(1);
            ic_q <= (ic_q == ivl - CW'(1)) ? '0 : ic_q + CW'(1);
        end
    end

    assign act_o = run && en && (pr_q == '0) && in_high(ph_q, lcfg.high);
    assign pad_o = run && en && (pr_q != '0);

    // R4: the pattern position is frozen across a padding cycle
    a_r4_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (pad_o && !clear) |=> $stable(ph_q));

    // R3: a padding burst starts exactly at an interval boundary
    a_r3_burst_aligned: assert property (@(posedge clk) disable iff (rst)
        $rose(pad_o) |-> (ic_q == '0));

endmodule

// File: rtl/dither_pattern_gen.sv
module dither_pattern_gen
    import dpg_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int CW     = 32,
    parameter int CNW    = $clog2(NCORES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              approx_en,
    input  logic [FW-1:0]     cfg_high,
    input  logic [FW-1:0]     cfg_low,
    input  logic [MW-1:0]     cfg_sustain,
    input  logic [CNW-1:0]    cfg_cores,
    input  logic [FW-1:0]     cfg_delta,
    output logic [NCORES-1:0] act,
    output logic [NCORES-1:0] pad,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);
    seq_state_e    state_q;
    lane_cfg_t     lcfg_d, lcfg_q;
    logic [CW-1:0] pw_d [NCORES];
    logic [CW-1:0] pw_q [NCORES];
    logic [CNW-1:0] cores_q;
    logic [CW-1:0] gcnt_q;
    logic [CW-1:0] bound;
    logic          cfg_ok;
    logic          accept;
    logic          running;

    dpg_setup #(.NCORES(NCORES), .CW(CW), .CNW(CNW)) u_setup (
        .approx_en (approx_en),
        .high      (cfg_high),
        .low       (cfg_low),
        .sustain   (cfg_sustain),
        .delta     (cfg_delta),
        .cores     (cfg_cores),
        .lcfg      (lcfg_d),
        .pw        (pw_d),
        .cfg_ok    (cfg_ok)
    );

    assign running = (state_q == ST_RUN);
    assign accept  = start && !running && cfg_ok;
    assign busy    = running;

    always_comb begin
        bound = pw_q[0];
        for (int j = 0; j < NCORES; j++)
            if (32'(cores_q) == j + 1) bound = pw_q[j];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lcfg_q  <= '0;
            cores_q <= '0;
            gcnt_q  <= '0;
            done    <= 1'b0;
            cfg_err <= 1'b0;
            for (int j = 0; j < NCORES; j++) pw_q[j] <= '0;
        end else begin
            done <= 1'b0;
            if (!running) begin
                if (start) begin
                    cfg_err <= !cfg_ok;
                    if (cfg_ok) begin
                        state_q <= ST_RUN;
                        lcfg_q  <= lcfg_d;
                        cores_q <= cfg_cores;
                        gcnt_q  <= '0;
                        for (int j = 0; j < NCORES; j++) pw_q[j] <= pw_d[j];
                    end
                end
            end else begin
                gcnt_q <= gcnt_q + CW'(1);
                if (gcnt_q == bound - CW'(1)) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
            end
        end
    end

    for (genvar c = 0; c < NCORES; c++) begin : g_lane
        localparam int IX = (c == 0) ? 0 : c - 1;
        logic lane_en;
        assign lane_en = 32'(cores_q) > c;
        dpg_lane #(.CW(CW), .IS_REF(c == 0)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .clear (accept),
            .run   (running),
            .en    (lane_en),
            .ivl   (pw_q[IX]),
            .lcfg  (lcfg_q),
            .act_o (act[c]),
            .pad_o (pad[c])
        );
    end

    // R1: quiet outputs whenever no sweep runs
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (act == '0 && pad == '0));

    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: a sweep does not stop before its bound
    a_r6_run_continues: assert property (@(posedge clk) disable iff (rst)
        (busy && gcnt_q != bound - CW'(1)) |=> busy);

    // R7: a refused start never leaves a sweep running
    a_r7_err_blocks: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !busy);

endmodule

// File: tb/tb_dither_pattern_gen.sv
module tb_dither_pattern_gen;
    import dpg_pkg::*;

    localparam int NC  = 4;
    localparam int CNW = $clog2(NC + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic approx_en = 1'b0;
    logic [FW-1:0] cfg_high = '0, cfg_low = '0, cfg_delta = '0;
    logic [MW-1:0] cfg_sustain = '0;
    logic [CNW-1:0] cfg_cores = '0;
    logic [NC-1:0] act, pad;
    logic busy, done, cfg_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dither_pattern_gen #(.NCORES(NC)) dut (
        .clk(clk), .rst(rst), .start(start), .approx_en(approx_en),
        .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_sustain(cfg_sustain),
        .cfg_cores(cfg_cores), .cfg_delta(cfg_delta),
        .act(act), .pad(pad), .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    task automatic chk(string req, int got, int exp, int t);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, got, exp);
        end
    endtask

    function automatic int ipow(int b, int e);
        int r = 1;
        for (int i = 0; i < e; i++) r = r * b;
        return r;
    endfunction

    function automatic int pads_before(int t, int ivl, int plen);
        int s = 0;
        for (int e = 1; e * ivl < t; e++)
            s += ((t - e * ivl) < plen) ? (t - e * ivl) : plen;
        return s;
    endfunction

    task automatic run_cfg(int h, int l, int m, int c, int dl, bit ap, bit poke);
        int p, plen, step, bound;
        int ea, ep;
        p = h + l;
        plen = ap ? dl + 1 : 1;
        step = ap ? p / (dl + 1) : p;
        bound = m * ipow(step, c - 1);
        cfg_high = FW'(h); cfg_low = FW'(l); cfg_sustain = MW'(m);
        cfg_cores = CNW'(c); cfg_delta = FW'(dl); approx_en = ap;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7 err cleared", int'(cfg_err), 0, 0);
        for (int t = 0; t < bound; t++) begin
            ea = 0; ep = 0;
            for (int cc = 0; cc < c; cc++) begin
                int ivl, np;
                bit pp;
                ivl = m * ipow(step, (cc == 0) ? 0 : cc - 1);
                pp = (cc != 0) && (t >= ivl) && ((t % ivl) < plen);
                np = (cc == 0) ? 0 : pads_before(t, ivl, plen);
                if (pp) ep |= (1 << cc);
                else if (((t - np) % p) < h) ea |= (1 << cc);
            end
            // poke: a second start with other settings mid-sweep (R9)
            if (poke && t == 2) begin
                start = 1'b1; cfg_high = FW'(h + 1); cfg_sustain = MW'(m + 3);
            end else start = 1'b0;
            chk("R6 busy", int'(busy), 1, t);
            chk("R2 core0", int'(act[0]), ea & 1, t);
            chk(ap ? "R5 pad" : "R3 pad", int'(pad), ep, t);
            chk(poke ? "R9 act" : "R4 act", int'(act), ea, t);
            chk("R8 idle lanes", int'((act | pad) >> c), 0, t);
            @(negedge clk);
        end
        start = 1'b0;
        chk("R6 done", int'(done), 1, bound);
        chk("R6 busy end", int'(busy), 0, bound);
        @(negedge clk);
        chk("R6 done once", int'(done), 0, bound + 1);
        chk("R1 idle outputs", int'({act, pad}), 0, bound + 1);
    endtask

    task automatic refuse(int h, int l, int m, int c, int dl, bit ap, string why);
        cfg_high = FW'(h); cfg_low = FW'(l); cfg_sustain = MW'(m);
        cfg_cores = CNW'(c); cfg_delta = FW'(dl); approx_en = ap;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({"R7 err ", why}, int'(cfg_err), 1, 0);
        for (int i = 0; i < 3; i++) begin
            chk({"R7 no run ", why}, int'({busy, act, pad}), 0, i);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed, h, l, m, c, dl, p, d1;
        bit ap;
        seed = 7;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", int'({act, pad, busy, done, cfg_err}), 0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", int'({act, pad, busy, done, cfg_err}), 0, 0);

        run_cfg(2, 1, 4, 3, 0, 1'b0, 1'b0);   // R3: cores 1 and 2 pad together at t=12,24
        run_cfg(3, 3, 3, 3, 1, 1'b1, 1'b0);   // R5: two-cycle pads, k=3
        run_cfg(1, 1, 2, 4, 0, 1'b0, 1'b0);   // four cores, bound 16
        run_cfg(3, 2, 5, 1, 0, 1'b0, 1'b0);   // single core: bound M
        run_cfg(2, 2, 3, 2, 0, 1'b0, 1'b1);   // R9 poke mid-sweep
        run_cfg(4, 0, 2, 2, 0, 1'b0, 1'b0);   // no low part

        refuse(3, 2, 4, 2, 1, 1'b1, "divisibility");
        refuse(0, 0, 4, 2, 0, 1'b0, "zero period");
        refuse(2, 2, 0, 2, 0, 1'b0, "zero sustain");
        refuse(2, 2, 4, 0, 0, 1'b0, "zero cores");
        refuse(2, 2, 4, 5, 0, 1'b0, "too many cores");
        refuse(2, 2, 2, 2, 3, 1'b1, "pad over sustain");

        for (int r = 0; r < 24; r++) begin
            h = 1 + int'($urandom % 4);
            l = int'($urandom % 4);
            p = h + l;
            c = 1 + int'($urandom % 3);
            ap = 1'($urandom % 2);
            dl = 0;
            if (ap) begin
                d1 = 1 + int'($urandom % p);
                if (p % d1 != 0) d1 = 1;
                dl = d1 - 1;
            end
            m = dl + 1 + int'($urandom % 6);
            run_cfg(h, l, m, c, dl, ap, 1'b0);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule